// File: doc/BRIEF.md
# Push-Multiple Store Sequencer

This block executes one push-multiple-registers instruction. It takes the instruction word, a format select, a condition pass/fail flag and the current stack pointer. It decodes the word in one of two formats: a 32-bit conditional format, or a compact format built from two 16-bit halves. From the decoded word it forms a 16-bit mask of selected registers. The stores form a full-descending block. The lowest address is worked out before the first write, from the stack pointer and the number of set mask bits. The registers then go out in ascending order, one word per accepted memory transfer, to consecutive ascending addresses. The last word lands just below the original stack pointer.

Register values come from a combinational register-file read port, addressed by the index of the register being stored. The memory side is a simple request/ready write port. A stalled request holds its address, data and byte enables. After the final accepted write, the block returns the new stack pointer, equal to the lowest address written, and pulses done.

Two other outcomes end an instruction without any writes. A word that does not decode as a push, including one that selects fewer than two registers, is rejected with a one-cycle flag. A word that decodes as a push but whose condition failed retires with a one-cycle done pulse.

Top module: `blkpush_seq`

## Requirements
- R1: With `fmt_compact_i`=0 the word is a push only if bits 31:28 are not 4'hF and bits 27:16 equal 12'h92D. The mask is then bits 15:0, with bit k selecting register k. Any other word is rejected: `not_push_o` is high for one cycle, in the cycle after start, with no write, no `done_o` and no stack pointer update.
- R2: With `fmt_compact_i`=1 the word is a push only if bits 31:16 equal 16'hE92D, bit 15 is 0 and bit 13 is 0. The mask is built as bit 14 (link register r14) plus bits 12:0 (r0 to r12). Any other word is rejected as in R1.
- R3: A decoded mask with fewer than two set bits is rejected as in R1.
- R4: A valid push started with `cond_pass_i`=0 retires with `done_o` high for one cycle, in the cycle after start. There is no write, and `sp_we_o` stays low.
- R5: With N selected registers and a start-time stack pointer SP, write number i (counting from 0) goes to address SP−4·N+4·i. It carries the i-th lowest selected register: `rf_idx_o` addresses that register and the write data is its value. If r13 is selected together with a lower register, its stored value is not defined.
- R6: While `mem_req_o` is high and `mem_rdy_i` is low, the address, data, register index and byte enables stay unchanged. All byte enables are high.
- R7: In the cycle after the last accepted write, `done_o` and `sp_we_o` are high together for one cycle, and `sp_wdata_o` equals SP−4·N. SP is the value sampled at start; later changes on `sp_i` have no effect.
- R8: `start_i` is ignored while an instruction is in progress: no extra write and no extra retire follows.
- R9: `busy_o` is high in every cycle from the cycle after start up to and including the retire or reject cycle, and low otherwise.
- R10: During reset `mem_req_o`, `done_o`, `not_push_o`, `sp_we_o` and `busy_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an instruction; sampled when idle |
| insn_i | input | 32 | Instruction word |
| fmt_compact_i | input | 1 | 0: 32-bit conditional format, 1: compact format |
| cond_pass_i | input | 1 | Condition result for this instruction |
| sp_i | input | ADDR_W | Current stack pointer, sampled at start |
| rf_idx_o | output | 4 | Register-file read index |
| rf_data_i | input | DATA_W | Value of the addressed register |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | ADDR_W | Write address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_be_o | output | DATA_W/8 | Byte enables |
| mem_rdy_i | input | 1 | Memory accepts the current request |
| sp_we_o | output | 1 | Stack pointer write-back strobe |
| sp_wdata_o | output | ADDR_W | New stack pointer value |
| done_o | output | 1 | Instruction retired (one cycle) |
| not_push_o | output | 1 | Word rejected as not a push (one cycle) |
| busy_o | output | 1 | Instruction in progress |

## Verification
The bound checker watches the memory port on every cycle. It checks that a stalled request stays frozen and that every byte lane is enabled. It also checks that each accepted write is followed by a higher address and a higher register index, and that the stack pointer strobe only appears with done, right after a completed transfer. Only the bench scenarios can show the decode results for both formats and the exact start address taken from the mask's population count. The same holds for the data carried by each register slot, the cycle in which the block retires, and whether a second start or a changed stack pointer during a run is ignored.

// File: rtl/blkpush_pkg.sv
package blkpush_pkg;
  localparam int REG_CNT   = 16;
  localparam int REG_IDX_W = $clog2(REG_CNT);
  localparam int CNT_W     = REG_IDX_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STORE,
    ST_FINISH,
    ST_SKIP,
    ST_REJECT
  } seq_state_t;

  typedef struct packed {
    logic               is_push;
    logic [REG_CNT-1:0] mask;
    logic [CNT_W-1:0]   count;
  } decode_t;
endpackage

// File: rtl/blkpush_decode.sv
module blkpush_decode
  import blkpush_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic        fmt_compact_i,
  output decode_t     dec_o
);
  localparam logic [11:0] WIDE_FIXED   = 12'h92D;
  localparam logic [15:0] COMPACT_HIGH = 16'hE92D;

  logic               wide_ok;
  logic               compact_ok;
  logic               fmt_ok;
  logic [REG_CNT-1:0] wide_mask;
  logic [REG_CNT-1:0] compact_mask;
  logic [REG_CNT-1:0] sel_mask;
  logic [CNT_W-1:0]   pop;

  // 32-bit conditional form: never-condition is excluded
  assign wide_ok   = (insn_i[31:28] != 4'hF) && (insn_i[27:16] == WIDE_FIXED);
  assign wide_mask = insn_i[15:0];

  // compact form: r13 and the P bit must be clear
  assign compact_ok   = (insn_i[31:16] == COMPACT_HIGH) && !insn_i[15] && !insn_i[13];
  assign compact_mask = {1'b0, insn_i[14], 1'b0, insn_i[12:0]};

  assign fmt_ok   = fmt_compact_i ? compact_ok : wide_ok;
  assign sel_mask = fmt_compact_i ? compact_mask : wide_mask;

  always_comb begin
    pop = '0;
    for (int i = 0; i < REG_CNT; i++) begin
      pop = pop + CNT_W'(sel_mask[i]);
    end
  end

  assign dec_o.mask    = sel_mask;
  assign dec_o.count   = pop;
  assign dec_o.is_push = fmt_ok && (pop > CNT_W'(1));
endmodule

// File: rtl/blkpush_prienc.sv
module blkpush_prienc #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  onehot_o,
  output logic          any_o
);
  // lowest set bit wins: scan from the top so lower indices overwrite
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  // isolate lowest set bit
  assign onehot_o = vec_i & (~vec_i + W'(1));
  assign any_o    = |vec_i;
endmodule

// File: rtl/blkpush_seq.sv
module blkpush_seq
  import blkpush_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [31:0]           insn_i,
  input  logic                  fmt_compact_i,
  input  logic                  cond_pass_i,
  input  logic [ADDR_W-1:0]     sp_i,
  output logic [REG_IDX_W-1:0]  rf_idx_o,
  input  logic [DATA_W-1:0]     rf_data_i,
  output logic                  mem_req_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  output logic [DATA_W/8-1:0]   mem_be_o,
  input  logic                  mem_rdy_i,
  output logic                  sp_we_o,
  output logic [ADDR_W-1:0]     sp_wdata_o,
  output logic                  done_o,
  output logic                  not_push_o,
  output logic                  busy_o
);
  localparam int BE_W       = DATA_W / 8;
  localparam int BYTE_SHIFT = $clog2(BE_W);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(BE_W);

  seq_state_t         state_q, state_d;
  logic [REG_CNT-1:0] mask_q, mask_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic               mask_en, addr_en, base_en;

  decode_t            dec;
  logic [REG_IDX_W-1:0] pick_idx;
  logic [REG_CNT-1:0] pick_bit;
  logic               pick_any;
  logic [REG_CNT-1:0] mask_left;
  logic [ADDR_W-1:0]  block_start;

  blkpush_decode u_decode (
    .insn_i        (insn_i),
    .fmt_compact_i (fmt_compact_i),
    .dec_o         (dec)
  );

  blkpush_prienc #(.W(REG_CNT), .IW(REG_IDX_W)) u_pick (
    .vec_i    (mask_q),
    .idx_o    (pick_idx),
    .onehot_o (pick_bit),
    .any_o    (pick_any)
  );

  // lowest address of the block, known before the first write
  assign block_start = sp_i - (ADDR_W'(dec.count) << BYTE_SHIFT);
  assign mask_left   = mask_q & ~pick_bit;

  // next-state and datapath control
  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    addr_d  = addr_q;
    base_d  = base_q;
    mask_en = 1'b0;
    addr_en = 1'b0;
    base_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (!dec.is_push) begin
            state_d = ST_REJECT;
          end else if (!cond_pass_i) begin
            state_d = ST_SKIP;
          end else begin
            state_d = ST_STORE;
            mask_d  = dec.mask;
            addr_d  = block_start;
            base_d  = block_start;
            mask_en = 1'b1;
            addr_en = 1'b1;
            base_en = 1'b1;
          end
        end
      end
      ST_STORE: begin
        if (mem_rdy_i && pick_any) begin
          mask_d  = mask_left;
          addr_d  = addr_q + WORD_STEP;
          mask_en = 1'b1;
          addr_en = 1'b1;
          if (mask_left == '0) state_d = ST_FINISH;
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      ST_SKIP:   state_d = ST_IDLE;
      ST_REJECT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      addr_q <= '0;
      base_q <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (addr_en) addr_q <= addr_d;
      if (base_en) base_q <= base_d;
    end
  end

  assign rf_idx_o    = pick_idx;
  assign mem_req_o   = (state_q == ST_STORE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = rf_data_i;
  assign mem_be_o    = {BE_W{1'b1}};
  assign sp_we_o     = (state_q == ST_FINISH);
  assign sp_wdata_o  = base_q;
  assign done_o      = (state_q == ST_FINISH) || (state_q == ST_SKIP);
  assign not_push_o  = (state_q == ST_REJECT);
  assign busy_o      = (state_q != ST_IDLE);
endmodule

// File: rtl/blkpush_seq_chk.sv
module blkpush_seq_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [3:0]          rf_idx_o,
  input logic                mem_req_o,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic [DATA_W-1:0]   mem_wdata_o,
  input logic [DATA_W/8-1:0] mem_be_o,
  input logic                mem_rdy_i,
  input logic                sp_we_o,
  input logic                done_o,
  input logic                not_push_o,
  input logic                busy_o
);
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(rf_idx_o) && $stable(mem_be_o)); // R6
  AST_FULL_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> $countones(mem_be_o) == DATA_W / 8); // R6
  AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_rdy_i |=> !mem_req_o || (mem_addr_o == $past(mem_addr_o) + ADDR_W'(DATA_W / 8))); // R5
  AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_rdy_i |=> !mem_req_o || (rf_idx_o > $past(rf_idx_o))); // R5
  AST_SP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we_o |-> done_o && !mem_req_o); // R7
  AST_SP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we_o |-> $past(mem_req_o && mem_rdy_i)); // R7
  AST_RETIRE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, not_push_o, mem_req_o})); // R4
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    not_push_o |=> !mem_req_o && !done_o); // R3
  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o || done_o || not_push_o) |-> busy_o); // R9
endmodule

bind blkpush_seq blkpush_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rf_idx_o    (rf_idx_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_be_o    (mem_be_o),
  .mem_rdy_i   (mem_rdy_i),
  .sp_we_o     (sp_we_o),
  .done_o      (done_o),
  .not_push_o  (not_push_o),
  .busy_o      (busy_o)
);

// File: tb/blkpush_seq_tb.sv
module blkpush_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] insn_i;
  logic        fmt_compact_i;
  logic        cond_pass_i;
  logic [31:0] sp_i;
  logic [3:0]  rf_idx_o;
  logic [31:0] rf_data_i;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic        mem_rdy_i;
  logic        sp_we_o;
  logic [31:0] sp_wdata_o;
  logic        done_o;
  logic        not_push_o;
  logic        busy_o;

  logic [31:0] rf [16];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  assign rf_data_i = rf[rf_idx_o];

  blkpush_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
    .fmt_compact_i(fmt_compact_i), .cond_pass_i(cond_pass_i), .sp_i(sp_i),
    .rf_idx_o(rf_idx_o), .rf_data_i(rf_data_i), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o),
    .mem_rdy_i(mem_rdy_i), .sp_we_o(sp_we_o), .sp_wdata_o(sp_wdata_o),
    .done_o(done_o), .not_push_o(not_push_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_mask(input logic [31:0] w, input bit cmp, output bit ok);
    if (cmp) begin
      ok = (w[31:16] == 16'hE92D) && !w[15] && !w[13];
      return {1'b0, w[14], 1'b0, w[12:0]};
    end
    ok = (w[31:28] != 4'hF) && (w[27:16] == 12'h92D);
    return w[15:0];
  endfunction

  function automatic int popc(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic int reg_at(input logic [15:0] m, input int n);
    int k = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if (k == n) return i;
        k++;
      end
    end
    return -1;
  endfunction

  function automatic logic [31:0] enc_wide(input logic [3:0] c, input logic [15:0] m);
    return {c, 12'h92D, m};
  endfunction

  function automatic logic [31:0] enc_compact(input bit lr, input logic [12:0] l);
    return {16'hE92D, 1'b0, lr, 1'b0, l};
  endfunction

  task automatic run_op(input logic [31:0] w, input bit cmp, input bit pass,
                        input logic [31:0] sp, input bit poke, input string dtag);
    bit ok, valid, fin, poked;
    logic [15:0] m;
    logic [31:0] base;
    int pc, n, cyc, acc_cyc, r;
    m = ref_mask(w, cmp, ok);
    pc = popc(m);
    valid = ok && (pc > 1);
    base = sp - 32'(4 * pc);
    @(negedge clk);
    start_i = 1'b1; insn_i = w; fmt_compact_i = cmp; cond_pass_i = pass; sp_i = sp;
    @(negedge clk);
    start_i = 1'b0; sp_i = $urandom; insn_i = $urandom;
    chk(busy_o, "R9", "busy after start", 32'(busy_o), 32'd1);
    if (!valid) begin
      chk(not_push_o && !done_o && !mem_req_o && !sp_we_o, dtag, "reject flags",
          {28'd0, not_push_o, done_o, mem_req_o, sp_we_o}, 32'h8);
    end else if (!pass) begin
      chk(done_o && !sp_we_o && !mem_req_o && !not_push_o, "R4", "cond fail retire",
          {28'd0, not_push_o, done_o, mem_req_o, sp_we_o}, 32'h4);
    end else begin
      n = 0; cyc = 0; fin = 0; acc_cyc = -10; poked = 0;
      while (!fin && cyc < 400) begin
        start_i = 1'b0;
        if (mem_req_o) begin
          r = reg_at(m, n);
          chk(mem_addr_o == base + 32'(4 * n), "R5", "write address", mem_addr_o, base + 32'(4 * n));
          chk(int'(rf_idx_o) == r, "R5", "register order", 32'(rf_idx_o), 32'(r));
          if (!(r == 13 && (m & 16'h1FFF) != 16'h0))
            chk(mem_wdata_o == rf[r], "R5", "write data", mem_wdata_o, rf[r]);
          chk(mem_be_o == 4'hF, "R6", "byte enables", 32'(mem_be_o), 32'hF);
          mem_rdy_i = (($urandom % 3) != 0);
          if (mem_rdy_i) begin
            n++;
            acc_cyc = cyc;
            if (poke && !poked) begin
              poked = 1;
              start_i = 1'b1; insn_i = enc_wide(4'h0, 16'hFFFF); fmt_compact_i = 1'b0; cond_pass_i = 1'b1;
            end
          end
        end else begin
          mem_rdy_i = 1'b0;
          fin = 1;
          chk(done_o && !not_push_o, "R7", "retire after writes", 32'(done_o), 32'd1);
          chk(n == pc, "R5", "write count", 32'(n), 32'(pc));
          chk(sp_we_o && sp_wdata_o == base, "R7", "sp write-back", sp_wdata_o, base);
          chk(cyc == acc_cyc + 1, "R7", "done timing", 32'(cyc), 32'(acc_cyc + 1));
        end
        @(negedge clk);
        cyc++;
      end
      if (!fin) chk(0, "R7", "no retire", 32'(cyc), 32'd0);
      start_i = 1'b0;
      mem_rdy_i = 1'b0;
      if (fin) begin
        chk(!busy_o && !mem_req_o && !done_o && !sp_we_o, poke ? "R8" : "R9", "idle after retire",
            {28'd0, busy_o, mem_req_o, done_o, sp_we_o}, 32'h0);
        return;
      end
    end
    @(negedge clk);
    chk(!busy_o && !mem_req_o && !done_o && !not_push_o, "R9", "idle after op",
        {28'd0, busy_o, mem_req_o, done_o, not_push_o}, 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) rf[i] = $urandom;
    rst_n = 1'b0; start_i = 1'b0; insn_i = '0; fmt_compact_i = 1'b0;
    cond_pass_i = 1'b1; sp_i = 32'h1000; mem_rdy_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mem_req_o && !done_o && !not_push_o && !sp_we_o && !busy_o, "R10", "reset outputs",
        {27'd0, mem_req_o, done_o, not_push_o, sp_we_o, busy_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !mem_req_o, "R10", "idle after reset", {30'd0, busy_o, mem_req_o}, 32'h0);

    run_op(enc_wide(4'hE, 16'h4003), 0, 1, 32'h0000_8000, 0, "R1");
    run_op(enc_wide(4'h1, 16'hFFFF), 0, 1, 32'h0002_0000, 0, "R1");
    run_op(enc_wide(4'hE, 16'h0010), 0, 1, 32'h0000_8000, 0, "R3");
    run_op(enc_wide(4'hE, 16'h0000), 0, 1, 32'h0000_8000, 0, "R3");
    run_op(enc_wide(4'hF, 16'h00FF), 0, 1, 32'h0000_8000, 0, "R1");
    run_op(enc_wide(4'hE, 16'h00FF) & ~32'h0020_0000, 0, 1, 32'h0000_8000, 0, "R1");
    run_op(enc_compact(1'b1, 13'h0001), 1, 1, 32'h0000_4000, 0, "R2");
    run_op(enc_compact(1'b0, 13'h1FFF), 1, 1, 32'h0000_4000, 0, "R2");
    run_op(enc_compact(1'b0, 13'h0003) | 32'h0000_2000, 1, 1, 32'h0000_4000, 0, "R2");
    run_op(enc_compact(1'b0, 13'h0003) | 32'h0000_8000, 1, 1, 32'h0000_4000, 0, "R2");
    run_op(enc_compact(1'b1, 13'h0000), 1, 1, 32'h0000_4000, 0, "R3");
    run_op(enc_wide(4'hE, 16'h0003), 1, 1, 32'h0000_4000, 0, "R2");
    run_op(enc_wide(4'hE, 16'h0F00), 0, 0, 32'h0000_4000, 0, "R4");
    run_op(enc_wide(4'hE, 16'h6000), 0, 1, 32'h0000_3000, 0, "R5");
    run_op(enc_wide(4'hE, 16'h2003), 0, 1, 32'h0000_3000, 0, "R5");
    run_op(enc_wide(4'hE, 16'h00F1), 0, 1, 32'h0000_0008, 1, "R8");

    for (int k = 0; k < 60; k++) begin
      bit cmp = $urandom % 2;
      bit pass = ($urandom % 8) != 0;
      logic [31:0] w;
      logic [31:0] sp = $urandom & ~32'h3;
      for (int i = 0; i < 16; i++) rf[i] = $urandom;
      if (cmp) w = enc_compact(1'($urandom), 13'($urandom) & 13'($urandom));
      else     w = enc_wide(4'($urandom % 15), 16'($urandom) & 16'($urandom));
      run_op(w, cmp, pass, sp, (k % 7) == 0, cmp ? "R2" : "R1");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule